// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one independent channel of an interval timer. It counts pulses of a channel clock, presented as a single-cycle `tick` enable that is synchronous to the host clock. The channel holds a 16-bit down-counting element, which can count in binary or in four-digit BCD. A host-side decoder drives the block through simple strobes. One strobe selects the counting mode and the BCD flag. Two strobes write the low and high bytes of the count register. Two more strobes snapshot the counting element and the status byte into latches that the host can read.

A written count does not go straight into the counting element. It waits in the count register, and a channel tick moves it into the element. In modes that need a trigger, a rising edge on `gate` starts that move instead. Which ticks load the element, how `gate` acts, and how `out` behaves all depend on the mode. The modes are:

- interrupt on terminal count
- gate-retriggered one-shot
- rate generator
- square wave
- software-triggered strobe
- gate-triggered strobe

Top module: `timer_channel`

## Requirements
- R1: After reset, `out` is high, the mode is 0, binary counting is selected, and no count is pending. A status snapshot then reads 0x80, and a count snapshot reads 0.
- R2: A configuration write sets the mode (values 6 and 7 behave as 2 and 3) and the BCD flag, and stops any count in progress. `out` is low after it in mode 0 and high after it in every other mode. The status byte is laid out as follows: bit 7 is `out`, bit 6 is the pending flag, bits 5:4 are zero, bit 3 is the BCD flag, and bits 2:0 are the mode as written.
- R3: `wr_lo` and `wr_hi` store the low and high bytes of the count register. A high-byte write commits the count and sets the pending flag. The pending flag clears when the count moves into the counting element.
- R4: Mode 0: a high-byte write drives `out` low. The next tick loads the element. `out` goes high on the Nth tick after the load tick. While `gate` is low, ticks do not change the count.
- R5: Mode 1: a `gate` rising edge followed by a tick loads the count and drives `out` low. `out` goes high N ticks after that load tick. A new rising edge during the count restarts it from N.
- R6: Mode 2: counting from the load tick (index 0), `out` is low on exactly the ticks whose index modulo N equals N-1. The count reloads every N ticks.
- R7: Mode 3: counting from the load tick (index 0), `out` is low on the ticks whose index modulo N is at least (N+1)/2, using integer division. An odd N therefore gives a high phase one tick longer than the low phase.
- R8: Mode 4: the tick after the high-byte write loads the count. `out` is low only on the Nth tick after the load tick. Mode 5 does the same, but a `gate` rising edge must arm the load; without that edge, ticks leave `out` high.
- R9: In modes 2 and 3, a low `gate` forces `out` high on the next clock and halts counting. A later rising edge makes the next tick reload the count.
- R10: `latch_cnt` copies the counting element into `cnt_q`. In modes 0, 1, 4 and 5, the value after tick index j (for j no greater than N) is N-j, encoded in the selected radix.
- R11: In BCD mode, the element counts down through valid decimal digits only. A BCD count is written as one decimal digit per nibble, with the least significant digit in bits 3:0.
- R12: A count of zero means the largest count: one tick after loading 0, the element reads 0xFFFF in binary and 0x9999 in BCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle channel clock enable |
| gate | input | 1 | Gate level, synchronous to `clk` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Counting mode for the configuration write |
| cfg_bcd | input | 1 | BCD flag for the configuration write |
| wr_lo | input | 1 | Count register low byte write |
| wr_hi | input | 1 | Count register high byte write (commits the count) |
| wr_data | input | 8 | Count byte |
| latch_cnt | input | 1 | Snapshot the counting element into `cnt_q` |
| latch_sts | input | 1 | Snapshot the status byte into `sts_q` |
| out | output | 1 | Channel output |
| cnt_q | output | 16 | Latched count |
| sts_q | output | 8 | Latched status byte |

## Verification
`out` and the counting element change on the clock edge that samples `tick`, so each output result is due one clock after the tick strobe. The bench raises a strobe at a falling edge, lowers it at the next falling edge, and reads the result there. A `gate` rising edge is registered on the clock after it appears and takes effect only at the following tick. The bench therefore holds `gate` steady for a full clock before it issues that tick. Snapshot values are due one clock after `latch_cnt` or `latch_sts`, and the bench raises these strobes only in cycles that have no tick, so each snapshot holds the count that the previous tick left.

// File: rtl/timer_channel.sv
module timer_channel #(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            gate,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_mode,
  input  logic            cfg_bcd,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [CW/2-1:0] wr_data,
  input  logic            latch_cnt,
  input  logic            latch_sts,
  output logic            out,
  output logic [CW-1:0]   cnt_q,
  output logic [7:0]      sts_q
);
  localparam int HW = CW / 2;
  localparam int ND = CW / 4;

  logic [2:0]    mode;
  logic          bcd, pend, armed, trig, have, gate_d, oddq;
  logic [CW-1:0] cr, ce;

  function automatic logic [CW-1:0] dec1(input logic [CW-1:0] v, input logic b);
    logic [CW-1:0] r;
    logic          br;
    if (!b) return v - 1'b1;
    r  = v;
    br = 1'b1;
    for (int i = 0; i < ND; i++) begin
      if (br) begin
        if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
        else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          br = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic bcd_ok(input logic [CW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ND; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic [2:0] em;
  assign em = mode[1] ? {1'b0, mode[1:0]} : mode;

  wire           rise     = gate & ~gate_d;
  wire           periodic = (em == 3'd2) || (em == 3'd3);
  wire           gated    = (em == 3'd1) || (em == 3'd5);
  wire           run_ok   = gated || gate;
  wire [CW-1:0]  next1    = dec1(ce, bcd);
  wire [CW-1:0]  next2    = dec1(next1, bcd);
  wire [CW-1:0]  ld_val   = (em == 3'd3) ? {cr[CW-1:1], 1'b0} : cr;
  wire           m3_edge  = (oddq && out) ? (ce == '0) : (ce == CW'(2));
  wire           load_now = tick && (gated ? (trig && have)
                                   : periodic ? ((pend && !armed) || (trig && have))
                                   : pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;  bcd   <= 1'b0; pend <= 1'b0; armed <= 1'b0;
      trig  <= 1'b0; have <= 1'b0; gate_d <= 1'b0; oddq <= 1'b0;
      cr    <= '0;  ce    <= '0;   out  <= 1'b1;
      cnt_q <= '0;  sts_q <= '0;
    end else begin
      gate_d <= gate;
      if (tick) trig <= 1'b0;
      if (load_now) begin
        ce    <= ld_val;
        oddq  <= cr[0];
        pend  <= 1'b0;
        armed <= 1'b1;
        out   <= !(em == 3'd0 || em == 3'd1);
      end else if (tick && armed && run_ok) begin
        unique case (em)
          3'd0, 3'd1: begin
            ce <= next1;
            if (ce == CW'(1)) out <= 1'b1;
          end
          3'd2: begin
            if (ce == CW'(1)) begin
              ce <= cr; pend <= 1'b0; out <= 1'b1;
            end else begin
              ce <= next1; out <= !(ce == CW'(2));
            end
          end
          3'd3: begin
            if (m3_edge) begin
              ce <= ld_val; oddq <= cr[0]; pend <= 1'b0; out <= !out;
            end else ce <= next2;
          end
          default: begin
            if (!out) begin
              out <= 1'b1; armed <= 1'b0;
            end else begin
              ce <= next1; out <= !(ce == CW'(1));
            end
          end
        endcase
      end
      if (periodic && !gate) out <= 1'b1;
      if (rise) trig <= 1'b1;
      if (wr_lo) cr[HW-1:0] <= wr_data;
      if (wr_hi) begin
        cr[CW-1:HW] <= wr_data;
        pend <= 1'b1;
        have <= 1'b1;
        if (em == 3'd0) out <= 1'b0;
        if (em == 3'd0 || em == 3'd4) armed <= 1'b0;
      end
      if (cfg_we) begin
        mode <= cfg_mode; bcd <= cfg_bcd;
        pend <= 1'b0; have <= 1'b0; armed <= 1'b0; trig <= 1'b0;
        out  <= (cfg_mode != 3'd0);
      end
      if (latch_cnt) cnt_q <= ce;
      if (latch_sts) sts_q <= {out, pend, 2'b00, bcd, mode};
    end
  end

  AST_CFG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (out == ($past(cfg_mode) != 3'd0)));  // R2
  AST_LOAD_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && tick && !cfg_we && !wr_hi && (em == 3'd0 || em == 3'd4)) |=> !pend);  // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_we) |=> $stable(ce));  // R4
  AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((em == 3'd4 || em == 3'd5) && !out) |-> (ce == '0));  // R8
  AST_GATE_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && !gate && !cfg_we) |=> out);  // R9
  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd && armed) |-> bcd_ok(ce));  // R11
endmodule

// File: tb/tb_timer_channel.sv
`timescale 1ns/1ps
module tb_timer_channel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, gate = 1, cfg_we = 0, cfg_bcd = 0, wr_lo = 0, wr_hi = 0;
  logic latch_cnt = 0, latch_sts = 0;
  logic [2:0]  cfg_mode = '0;
  logic [7:0]  wr_data = '0;
  logic        out;
  logic [15:0] cnt_q;
  logic [7:0]  sts_q;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  timer_channel dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .latch_cnt(latch_cnt), .latch_sts(latch_sts),
    .out(out), .cnt_q(cnt_q), .sts_q(sts_q));

  function automatic logic [15:0] enc(int v, bit b);
    if (!b) return 16'(v);
    return {4'((v / 1000) % 10), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic exp_out(int m, int n, int j);
    case (m)
      0, 1:    return j >= n;
      2, 6:    return (j % n) != n - 1;
      3, 7:    return (j % n) < (n + 1) / 2;
      default: return j != n;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic configure(int m, bit b);
    @(negedge clk) begin cfg_we = 1; cfg_mode = 3'(m); cfg_bcd = b; end
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic write_count(logic [15:0] v);
    @(negedge clk) begin wr_lo = 1; wr_data = v[7:0]; end
    @(negedge clk) begin wr_lo = 0; wr_hi = 1; wr_data = v[15:8]; end
    @(negedge clk) wr_hi = 0;
  endtask

  task automatic snap_cnt();
    @(negedge clk) latch_cnt = 1;
    @(negedge clk) latch_cnt = 0;
  endtask

  task automatic snap_sts();
    @(negedge clk) latch_sts = 1;
    @(negedge clk) latch_sts = 0;
  endtask

  task automatic gate_pulse();
    @(negedge clk) gate = 0;
    @(negedge clk) gate = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out", out, 1);
    snap_sts(); chk("R1 status", sts_q, 8'h80);
    snap_cnt(); chk("R1 count", cnt_q, 0);

    // R2 / R3: status layout and pending flag
    configure(3, 1);
    chk("R2 out after cfg mode3", out, 1);
    write_count(enc(7, 1));
    snap_sts(); chk("R3 pending status", sts_q, 8'hCB);
    step_tick();
    snap_sts(); chk("R3 pending cleared", sts_q, 8'h8B);

    // R4 gate pause in mode 0
    configure(0, 0);
    chk("R2 out after cfg mode0", out, 0);
    write_count(16'd10);
    for (int j = 0; j <= 3; j++) step_tick();
    @(negedge clk) gate = 0;
    for (int k = 0; k < 4; k++) step_tick();
    snap_cnt(); chk("R4 paused count", cnt_q, 7);
    chk("R4 paused out", out, 0);
    @(negedge clk) gate = 1;
    step_tick();
    snap_cnt(); chk("R4 resumed count", cnt_q, 6);

    // R5 retrigger in mode 1
    @(negedge clk) gate = 0;
    configure(1, 0);
    write_count(16'd6);
    @(negedge clk) gate = 1;
    @(negedge clk);
    step_tick();
    chk("R5 out low at load", out, 0);
    for (int j = 1; j <= 4; j++) step_tick();
    snap_cnt(); chk("R5 count before retrigger", cnt_q, 2);
    gate_pulse();
    step_tick();
    snap_cnt(); chk("R5 reloaded count", cnt_q, 6);
    for (int j = 1; j <= 5; j++) step_tick();
    chk("R5 still low after retrigger", out, 0);
    step_tick();
    chk("R5 high at terminal", out, 1);

    // R9 gate low in mode 2
    configure(2, 0);
    write_count(16'd5);
    for (int j = 0; j <= 4; j++) step_tick();
    chk("R6 low on N-1", out, 0);
    @(negedge clk) gate = 0;
    @(negedge clk);
    chk("R9 forced high", out, 1);
    snap_cnt();
    begin
      logic [15:0] held;
      held = cnt_q;
      step_tick();
      snap_cnt(); chk("R9 halted count", cnt_q, held);
    end
    @(negedge clk) gate = 1;
    @(negedge clk);
    for (int j = 0; j <= 4; j++) begin
      step_tick();
      chk("R9 restart pattern", out, exp_out(2, 5, j));
    end

    // R12 zero means max count
    configure(0, 0);
    write_count(16'd0);
    step_tick(); step_tick();
    snap_cnt(); chk("R12 binary max", cnt_q, 16'hFFFF);
    chk("R12 binary out", out, 0);
    configure(0, 1);
    write_count(16'd0);
    step_tick(); step_tick();
    snap_cnt(); chk("R12 bcd max", cnt_q, 16'h9999);

    // R8 mode 5 without trigger
    configure(5, 0);
    write_count(16'd3);
    for (int k = 0; k < 6; k++) begin
      step_tick();
      chk("R8 mode5 untriggered", out, 1);
    end

    // random runs across modes
    for (int it = 0; it < 30; it++) begin
      int m, n;
      bit b, g;
      m = int'($urandom % 8);
      b = 1'($urandom % 2);
      n = 2 + int'($urandom % 40);
      g = (m == 1 || m == 5);
      @(negedge clk) gate = !g;
      configure(m, b);
      chk("R2 cfg level", out, m != 0);
      write_count(enc(n, b));
      chk("R4 level before load", out, m != 0);
      if (g) begin
        @(negedge clk) gate = 1;
        @(negedge clk);
      end
      for (int j = 0; j <= 2 * n + 2; j++) begin
        step_tick();
        case (m)
          0: chk("R4 mode0 out", out, exp_out(m, n, j));
          1: chk("R5 mode1 out", out, exp_out(m, n, j));
          2, 6: chk("R6 mode2 out", out, exp_out(m, n, j));
          3, 7: chk("R7 mode3 out", out, exp_out(m, n, j));
          default: chk("R8 strobe out", out, exp_out(m, n, j));
        endcase
        if ((m == 0 || m == 1 || m == 4 || m == 5) && j <= n && (j % 3 == 0 || j == n)) begin
          snap_cnt();
          if (b) chk("R11 bcd count", cnt_q, enc(n - j, 1));
          else   chk("R10 latched count", cnt_q, enc(n - j, 0));
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule